// File: doc/BRIEF.md
# Configurable Pointwise Convolution Engine

This block evaluates a 1×1 convolution over 8-bit signed activations and 8-bit signed weights. It has a fixed budget of multiplications per cycle, and that budget can be split between input-channel and output-channel parallelism in two ways. The square split (16 inputs × 16 outputs) suits layers with few channels. The deep split (32 inputs × 8 outputs) halves the number of output lanes that downstream logic must handle, and in exchange it reads twice as many activations per cycle. The split is held in a configuration register that can be rewritten at runtime. The adder tree regroups its product sums to match the split in force.

Weights are held in registers while a stream of input pixels passes through, one activation vector per cycle. Each pixel arrives with the stored 32-bit partial sums for its output lanes. The engine adds its dot products to those sums and returns the result a fixed three cycles later, together with a valid strobe and a flag that marks the last input-channel group. Products are computed two at a time. A pair of weights that share one activation is packed into a single wide operand, and the two results are then separated again with a sign correction.

Top module: `pwc_engine`

## Requirements
- R1: Activation lane i is `act_in[8i+7:8i]` and partial-sum lane o is `psum_in/psum_out[32o+31:32o]`. With `cfg_deep` = 0 stored (square split), output lane o (0..15) equals psum lane o plus the sum over i = 0..15 of act[i]·W[16o+i], where W[m] is product weight index m.
- R2: With `cfg_deep` = 1 stored (deep split), output lane o (0..7) equals psum lane o plus the sum over i = 0..31 of act[i]·W[32o+i].
- R3: In the deep split, output lanes 8..15 read zero whatever `psum_in` holds in those lanes.
- R4: In the square split, activation lanes 16..31 have no effect on any output lane.
- R5: All operands are two's complement, and every product is exact over the full range −128..127, including −128·−128.
- R6: The partial sum is added across its full 32 bits modulo 2^32, so large positive, large negative and sign-crossing stored sums are all handled.
- R7: `out_valid` is high exactly three clock edges after each edge that samples `in_valid` high, and it is low otherwise. Pixels may arrive on consecutive cycles.
- R8: `out_last` is high exactly when `out_valid` is high and the matching input carried `in_last` high.
- R9: A configuration write (`cfg_we` high at an edge) applies to pixels sampled at later edges. A pixel sampled at the same edge, or a pixel already in flight, keeps the previous split. The split does not change without a write.
- R10: A weight write stores `wt_data` lane j (bits 8j+7:8j) as W[32·`wt_addr`+j]. It applies to pixels sampled at later edges, and a pixel sampled at the same edge uses the old weights.
- R11: After reset, `out_valid`, `out_last` and `psum_out` are zero, the split is square and all weights are zero, so a pixel returns its partial sums unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the split register |
| cfg_deep | input | 1 | Split code written: 0 square, 1 deep |
| wt_we | input | 1 | Weight word write strobe |
| wt_addr | input | 3 | Weight word index |
| wt_data | input | 256 | Thirty-two 8-bit weights of one word |
| in_valid | input | 1 | Input pixel valid |
| in_last | input | 1 | Pixel belongs to the last input-channel group |
| act_in | input | 256 | Thirty-two 8-bit signed activations |
| psum_in | input | 512 | Sixteen 32-bit stored partial sums |
| out_valid | output | 1 | Output partial sums valid |
| out_last | output | 1 | Output partial sums are final |
| psum_out | output | 512 | Sixteen 32-bit updated partial sums |

## Verification
A fault in the packed-multiplier split, such as a missing sign correction or a wrong field offset, corrupts the output lanes whenever the lower product of a pair is negative. It appears at `psum_out` three edges after the pixel is sampled. A wrong regrouping or a stale split register shows up either as wrong sums in lanes 0..7 or as nonzero upper lanes on the first deep-split pixel. The square and deep vectors use mixed-sign and extreme operands so that each of these faults is seen on the first pixel affected. A pipeline mismatch between valid, last and the data shows up on back-to-back pixels and on the pixels that straddle a weight or split write.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
   typedef enum logic {
      SPLIT_SQUARE = 1'b0,
      SPLIT_DEEP   = 1'b1
   } split_e;
endpackage

// File: rtl/pwc_wt_bank.sv
`timescale 1ns/1ps
// Stationary weight registers, written one row of ROW weights at a time.
module pwc_wt_bank #(
   parameter int DW   = 8,
   parameter int ROW  = 32,
   parameter int NROW = 8,
   parameter int AW   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [AW-1:0]         addr,
   input  logic [ROW*DW-1:0]     data,
   output logic signed [DW-1:0]  w [ROW*NROW]
);
   if (NROW > (1 << AW)) begin : g_bad_aw
      $error("pwc_wt_bank: AW too narrow for NROW");
   end

   for (genvar r = 0; r < NROW; r++) begin : g_row
      logic [ROW*DW-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        row_q <= '0;
         else if (we && addr == AW'(r))     row_q <= data;
      end
      for (genvar j = 0; j < ROW; j++) begin : g_lane
         assign w[r*ROW+j] = row_q[j*DW +: DW];
      end
   end
endmodule

// File: rtl/pwc_pack_mul.sv
`timescale 1ns/1ps
// Two signed products sharing one activation, computed by one wide multiply.
// The upper weight sits at bit OFS; the lower field sign is folded back into the upper one.
module pwc_pack_mul #(
   parameter int DW    = 8,
   parameter int OFS   = 18,
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [DW-1:0]    a,
   input  logic signed [DW-1:0]    w_lo,
   input  logic signed [DW-1:0]    w_hi,
   output logic signed [ACC_W-1:0] p_lo,
   output logic signed [ACC_W-1:0] p_hi
);
   localparam int KW = OFS + 2*DW;

   if (OFS < 2*DW) begin : g_bad_ofs
      $error("pwc_pack_mul: OFS must leave room for a full lower product");
   end
   if (ACC_W < OFS) begin : g_bad_acc
      $error("pwc_pack_mul: ACC_W narrower than lower field");
   end

   logic signed [KW-1:0] lo_x, hi_x, a_x, pk, raw_d;
   logic        [KW-1:0] raw_q;
   logic        [OFS-1:0]  lo_f;
   logic        [2*DW-1:0] hi_f;

   always_comb begin
      lo_x  = KW'(w_lo);
      hi_x  = KW'(w_hi);
      a_x   = KW'(a);
      pk    = (hi_x <<< OFS) + lo_x;
      raw_d = pk * a_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_d;
   end

   assign lo_f = raw_q[OFS-1:0];
   assign hi_f = raw_q[KW-1:OFS] + {{(2*DW-1){1'b0}}, raw_q[OFS-1]};
   assign p_lo = ACC_W'($signed(lo_f));
   assign p_hi = ACC_W'($signed(hi_f));
endmodule

// File: rtl/pwc_adder_tree.sv
`timescale 1ns/1ps
// Group sums over GRP products, then regrouped per split into output lanes.
module pwc_adder_tree
   import pwc_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int GRP   = 16,
   parameter int NGRP  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  split_e                  mode_i,
   input  logic signed [ACC_W-1:0] prod_i [GRP*NGRP],
   output split_e                  mode_o,
   output logic [ACC_W-1:0]        sum_o  [NGRP]
);
   localparam int HALF = NGRP / 2;

   if (NGRP % 2 != 0) begin : g_bad_ngrp
      $error("pwc_adder_tree: NGRP must be even");
   end

   logic [ACC_W-1:0] gsum_d [NGRP];
   logic [ACC_W-1:0] gsum_q [NGRP];
   split_e           mode_q;

   always_comb begin
      for (int g = 0; g < NGRP; g++) begin
         gsum_d[g] = '0;
         for (int k = 0; k < GRP; k++) begin
            gsum_d[g] = gsum_d[g] + prod_i[g*GRP+k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SPLIT_SQUARE;
         for (int g = 0; g < NGRP; g++) gsum_q[g] <= '0;
      end else begin
         mode_q <= mode_i;
         for (int g = 0; g < NGRP; g++) gsum_q[g] <= gsum_d[g];
      end
   end

   assign mode_o = mode_q;

   for (genvar o = 0; o < NGRP; o++) begin : g_out
      if (o < HALF) begin : g_pair
         assign sum_o[o] = (mode_q == SPLIT_DEEP) ? gsum_q[2*o] + gsum_q[2*o+1]
                                                  : gsum_q[o];
      end else begin : g_single
         assign sum_o[o] = (mode_q == SPLIT_DEEP) ? '0 : gsum_q[o];
      end
   end
endmodule

// File: rtl/pwc_engine.sv
`timescale 1ns/1ps
// Pointwise convolution engine: weight-stationary multiplier array with a
// runtime split between input-channel and output-channel parallelism.
module pwc_engine
   import pwc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int ACC_W     = 32,
   parameter int IN_NARROW = 16,
   parameter int OUT_WIDE  = 16,
   parameter int PACK_OFS  = 18
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            cfg_deep,
   input  logic                            wt_we,
   input  logic [$clog2(OUT_WIDE/2)-1:0]   wt_addr,
   input  logic [2*IN_NARROW*DW-1:0]       wt_data,
   input  logic                            in_valid,
   input  logic                            in_last,
   input  logic [2*IN_NARROW*DW-1:0]       act_in,
   input  logic [OUT_WIDE*ACC_W-1:0]       psum_in,
   output logic                            out_valid,
   output logic                            out_last,
   output logic [OUT_WIDE*ACC_W-1:0]       psum_out
);
   localparam int N_MULT = IN_NARROW * OUT_WIDE;
   localparam int IN_MAX = 2 * IN_NARROW;
   localparam int N_PAIR = N_MULT / 2;
   localparam int N_WORD = N_MULT / IN_MAX;
   localparam int AW     = $clog2(N_WORD);
   localparam int HALF   = OUT_WIDE / 2;

   if (OUT_WIDE % 4 != 0) begin : g_bad_out
      $error("pwc_engine: OUT_WIDE must be a multiple of 4 for operand sharing");
   end
   if (N_WORD < 2) begin : g_bad_word
      $error("pwc_engine: at least two weight words required");
   end
   if (DW < 2 || ACC_W < 2*DW + $clog2(IN_MAX)) begin : g_bad_acc
      $error("pwc_engine: ACC_W too narrow for a full dot product");
   end

   split_e split_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      split_q <= SPLIT_SQUARE;
      else if (cfg_we) split_q <= split_e'(cfg_deep);
   end

   logic signed [DW-1:0] wt [N_MULT];
   pwc_wt_bank #(.DW(DW), .ROW(IN_MAX), .NROW(N_WORD), .AW(AW)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wt_we),
      .addr (wt_addr),
      .data (wt_data),
      .w    (wt)
   );

   // Product m and m+N_PAIR always read the same activation lane in both splits.
   logic signed [ACC_W-1:0] prod [N_MULT];
   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      localparam int LANE_SQ = p % IN_NARROW;
      localparam int LANE_DP = p % IN_MAX;
      logic signed [DW-1:0] a_sel;
      assign a_sel = (split_q == SPLIT_DEEP) ? act_in[LANE_DP*DW +: DW]
                                             : act_in[LANE_SQ*DW +: DW];
      pwc_pack_mul #(.DW(DW), .OFS(PACK_OFS), .ACC_W(ACC_W)) u_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .a    (a_sel),
         .w_lo (wt[p]),
         .w_hi (wt[p+N_PAIR]),
         .p_lo (prod[p]),
         .p_hi (prod[p+N_PAIR])
      );
   end

   // Side pipeline carrying strobes, split and stored sums beside the products.
   logic                      v1, l1, v2, l2;
   split_e                    mode1;
   logic [OUT_WIDE*ACC_W-1:0] ps1, ps2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; l1 <= 1'b0; v2 <= 1'b0; l2 <= 1'b0;
         mode1 <= SPLIT_SQUARE;
         ps1 <= '0; ps2 <= '0;
      end else begin
         v1 <= in_valid; l1 <= in_last; mode1 <= split_q; ps1 <= psum_in;
         v2 <= v1;       l2 <= l1;      ps2 <= ps1;
      end
   end

   split_e           tree_mode;
   logic [ACC_W-1:0] tree_sum [OUT_WIDE];
   pwc_adder_tree #(.ACC_W(ACC_W), .GRP(IN_NARROW), .NGRP(OUT_WIDE)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .mode_i(mode1),
      .prod_i(prod),
      .mode_o(tree_mode),
      .sum_o (tree_sum)
   );

   logic [ACC_W-1:0] lane_d [OUT_WIDE];
   for (genvar o = 0; o < OUT_WIDE; o++) begin : g_lane
      if (o < HALF) begin : g_live
         assign lane_d[o] = tree_sum[o] + ps2[o*ACC_W +: ACC_W];
      end else begin : g_gated
         assign lane_d[o] = (tree_mode == SPLIT_DEEP) ? '0
                                                      : tree_sum[o] + ps2[o*ACC_W +: ACC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         psum_out  <= '0;
      end else begin
         out_valid <= v2;
         out_last  <= v2 & l2;
         for (int o = 0; o < OUT_WIDE; o++) psum_out[o*ACC_W +: ACC_W] <= lane_d[o];
      end
   end
endmodule

// File: rtl/pwc_engine_chk.sv
`timescale 1ns/1ps
module pwc_engine_chk
   import pwc_pkg::*;
#(
   parameter int OUT_WIDE = 16,
   parameter int ACC_W    = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_we,
   input logic                      cfg_deep,
   input logic                      in_valid,
   input logic                      in_last,
   input logic                      out_valid,
   input logic                      out_last,
   input logic [OUT_WIDE*ACC_W-1:0] psum_out,
   input split_e                    split_q
);
   localparam int UPPER = (OUT_WIDE / 2) * ACC_W;

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R7

   AST_LAST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_last == $past(in_valid && in_last, 3))); // R8

   AST_DEEP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && $past(split_q, 3) == SPLIT_DEEP)
      |-> (psum_out[OUT_WIDE*ACC_W-1 -: UPPER] == '0)); // R3

   AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(split_q)); // R9

   AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (split_q == split_e'($past(cfg_deep)))); // R9
endmodule

bind pwc_engine pwc_engine_chk #(.OUT_WIDE(OUT_WIDE), .ACC_W(ACC_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_deep (cfg_deep),
   .in_valid (in_valid),
   .in_last  (in_last),
   .out_valid(out_valid),
   .out_last (out_last),
   .psum_out (psum_out),
   .split_q  (split_q)
);

// File: tb/test_pwc_engine.sv
`timescale 1ns/1ps
module test_pwc_engine;
   localparam int NL = 32;
   localparam int NO = 16;
   localparam int NW = 256;

   typedef struct packed {
      logic        deep;
      logic [7:0]  as;
      logic [7:0]  ao;
      logic [7:0]  ws;
      logic [7:0]  wo;
      logic [31:0] pbase;
   } vec_t;

   // split, activation step/offset, weight step/offset, partial-sum base
   localparam vec_t VECS [6] = '{
      '{1'b0, 8'd3,  8'd11,  8'd7,   8'd29,  32'h0000_0000},
      '{1'b0, 8'd0,  8'd0,   8'd0,   8'd0,   32'h0000_1000},
      '{1'b1, 8'd5,  8'd200, 8'd13,  8'd91,  32'hFFFF_FF00},
      '{1'b1, 8'd0,  8'd0,   8'd0,   8'd0,   32'h7FF0_0000},
      '{1'b1, 8'd1,  8'd128, 8'd255, 8'd127, 32'h8000_0000},
      '{1'b0, 8'd77, 8'd3,   8'd201, 8'd250, 32'h1234_5678}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0, cfg_deep = 1'b0;
   logic            wt_we = 1'b0;
   logic [2:0]      wt_addr = '0;
   logic [NL*8-1:0] wt_data = '0;
   logic            in_valid = 1'b0, in_last = 1'b0;
   logic [NL*8-1:0] act_in = '0;
   logic [NO*32-1:0] psum_in = '0;
   logic            out_valid, out_last;
   logic [NO*32-1:0] psum_out;

   int n_cmp = 0;
   int n_bad = 0;
   int tb_w [NW];
   int tb_a [NL];
   int cur_as = 0, cur_ao = 0;
   logic [31:0] cur_pb = '0;

   always #2.5 clk = ~clk;

   pwc_engine i_pwc_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_deep(cfg_deep),
      .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
      .in_valid(in_valid), .in_last(in_last), .act_in(act_in), .psum_in(psum_in),
      .out_valid(out_valid), .out_last(out_last), .psum_out(psum_out)
   );

   function automatic logic [NO*32-1:0] model(bit deep, logic [NO*32-1:0] ps);
      logic [NO*32-1:0] r;
      r = '0;
      for (int o = 0; o < NO; o++) begin
         int dot;
         dot = 0;
         if (!deep) begin
            for (int i = 0; i < 16; i++) dot += tb_a[i] * tb_w[o*16+i];
            r[o*32 +: 32] = ps[o*32 +: 32] + 32'(dot);
         end else if (o < 8) begin
            for (int i = 0; i < 32; i++) dot += tb_a[i] * tb_w[o*32+i];
            r[o*32 +: 32] = ps[o*32 +: 32] + 32'(dot);
         end
      end
      return r;
   endfunction

   task automatic check(string tag, bit ev, bit el, bit cmp_data, logic [NO*32-1:0] ex);
      n_cmp++;
      if (out_valid !== ev || out_last !== el || (cmp_data && psum_out !== ex)) begin
         n_bad++;
         $display("FAIL %s: actual valid=%0b last=%0b data=%h expected valid=%0b last=%0b data=%h",
                  tag, out_valid, out_last, psum_out, ev, el, ex);
      end
   endtask

   task automatic load_weights(int ws, int wo);
      for (int m = 0; m < NW; m++) tb_w[m] = ((m*ws + wo) % 256) - 128;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         wt_we = 1'b1;
         wt_addr = 3'(k);
         for (int j = 0; j < NL; j++) wt_data[j*8 +: 8] = 8'(tb_w[k*NL+j]);
      end
      @(negedge clk);
      wt_we = 1'b0;
   endtask

   task automatic write_split(bit d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_deep = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // upper == 1000 means lanes 16..31 follow the pattern too
   task automatic set_pixel(int pix, bit last, int upper);
      for (int i = 0; i < NL; i++) begin
         int v;
         v = ((i*cur_as + cur_ao + 17*pix) % 256) - 128;
         if (i >= 16 && upper != 1000) v = upper;
         tb_a[i] = v;
         act_in[i*8 +: 8] = 8'(v);
      end
      for (int o = 0; o < NO; o++) psum_in[o*32 +: 32] = cur_pb + 32'(o*257) + 32'(pix*16);
      in_valid = 1'b1;
      in_last = last;
   endtask

   task automatic go_idle();
      in_valid = 1'b0;
      in_last = 1'b0;
   endtask

   task automatic final_report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog: actual=hung expected=completed");
      final_report();
   end

   initial begin
      logic [NO*32-1:0] e0, e1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset state", 1'b0, 1'b0, 1'b1, '0);
      rst_n = 1'b1;

      // R11: zero weights and square split after reset return psum unchanged
      cur_as = 9; cur_ao = 1; cur_pb = 32'hA5A5_0000;
      @(negedge clk); set_pixel(0, 1'b1, 1000);
      e0 = psum_in;
      @(negedge clk); go_idle();
      @(negedge clk);
      @(negedge clk); check("R11 zero weights pass psum", 1'b1, 1'b1, 1'b1, e0);

      // Table of vectors, each streamed as two back-to-back pixels
      for (int e = 0; e < 6; e++) begin
         string tag;
         cur_as = int'(VECS[e].as);
         cur_ao = int'(VECS[e].ao);
         cur_pb = VECS[e].pbase;
         tag = VECS[e].deep ? "R2 R3 R6" : "R1 R4 R6";
         if (VECS[e].ws == 8'd0) tag = {tag, " R5"};
         load_weights(int'(VECS[e].ws), int'(VECS[e].wo));
         write_split(VECS[e].deep);
         @(negedge clk); set_pixel(0, 1'b0, 1000); e0 = model(VECS[e].deep, psum_in);
         @(negedge clk); set_pixel(1, 1'b1, 1000); e1 = model(VECS[e].deep, psum_in);
         @(negedge clk); go_idle();
         @(negedge clk); check({tag, " R7 first pixel"}, 1'b1, 1'b0, 1'b1, e0);
         @(negedge clk); check({tag, " R8 last pixel"}, 1'b1, 1'b1, 1'b1, e1);
         @(negedge clk); check("R7 R8 idle after stream", 1'b0, 1'b0, 1'b0, '0);
      end

      // R4: square split, upper activation lanes at opposite extremes
      @(negedge clk); set_pixel(6, 1'b0, 127);  e0 = model(1'b0, psum_in);
      @(negedge clk); set_pixel(6, 1'b1, -128); e1 = model(1'b0, psum_in);
      @(negedge clk); go_idle();
      @(negedge clk); check("R4 upper lanes high", 1'b1, 1'b0, 1'b1, e0);
      @(negedge clk); check("R4 upper lanes low", 1'b1, 1'b1, 1'b1, e1);
      @(negedge clk); check("R4 R7 idle", 1'b0, 1'b0, 1'b0, '0);

      // R9: split write at the same edge as pixel A; pixel B sees the new split
      @(negedge clk); set_pixel(2, 1'b0, 1000); cfg_we = 1'b1; cfg_deep = 1'b1;
      e0 = model(1'b0, psum_in);
      @(negedge clk); cfg_we = 1'b0; set_pixel(3, 1'b1, 1000);
      e1 = model(1'b1, psum_in);
      @(negedge clk); go_idle();
      @(negedge clk); check("R9 pixel with write keeps square", 1'b1, 1'b0, 1'b1, e0);
      @(negedge clk); check("R9 next pixel uses deep", 1'b1, 1'b1, 1'b1, e1);
      @(negedge clk); check("R9 R7 idle", 1'b0, 1'b0, 1'b0, '0);

      // R10: weight word 0 rewritten at the same edge as pixel A
      @(negedge clk); set_pixel(4, 1'b0, 1000); e0 = model(1'b1, psum_in);
      wt_we = 1'b1; wt_addr = 3'd0;
      for (int j = 0; j < NL; j++) begin
         tb_w[j] = (j % 2 == 0) ? 3 : -2;
         wt_data[j*8 +: 8] = 8'(tb_w[j]);
      end
      @(negedge clk); wt_we = 1'b0; set_pixel(5, 1'b1, 1000); e1 = model(1'b1, psum_in);
      @(negedge clk); go_idle();
      @(negedge clk); check("R10 pixel with write uses old weights", 1'b1, 1'b0, 1'b1, e0);
      @(negedge clk); check("R10 next pixel uses new weights", 1'b1, 1'b1, 1'b1, e1);
      @(negedge clk); check("R10 R7 idle", 1'b0, 1'b0, 1'b0, '0);

      final_report();
   end
endmodule